// File: doc/BRIEF.md
# DMA FIFO Packer with Threshold

This block is the byte-granular holding stage that sits between the read side and the write side of one DMA stream. Source beats of 1, 2 or 4 bytes go into a 16-byte circular store. Destination beats of 1, 2 or 4 bytes come out of it. Narrow source beats are therefore gathered into wide destination beats, and wide source beats are split into narrow ones. Bytes keep their arrival order, and lane 0 holds the oldest byte.

The destination side is told to start a burst once the stored byte count reaches a programmable quarter-fill mark. At the end of a transfer a flush input lets the remaining bytes leave even when they no longer fill a whole beat. The configuration is checked on every cycle: the burst length times the destination beat width must fit within the threshold. A setup that breaks this rule raises a sticky error flag, and that flag freezes both sides until reset.

Top module: `dma_fifo_packer`

## Requirements
- R1: Directly after reset the block reports empty = 1, full = 0, error = 0, burst request = 0 and destination valid = 0. Source ready is 1 while the configuration is legal.
- R2: Size codes 0, 1, 2 and 3 mean beats of 1, 2, 4 and 4 bytes. Source ready is 0 whenever the free space is less than the current source beat. The stored byte count never exceeds 16.
- R3: Narrow source beats are packed little-endian. The first byte received lands in bits 7:0 of the destination beat, and each later byte goes into the next lane up.
- R4: A wide source beat drained by narrower destination beats leaves lowest lane first.
- R5: Threshold codes 0, 1, 2 and 3 mean 4, 8, 12 and 16 bytes. The burst request is 1 exactly when the stored byte count is at or above the threshold and no error is flagged.
- R6: Without flush, destination valid is 1 only when at least one full destination beat is stored. A destination ready strobe while valid is 0 removes no data.
- R7: While flush is 1 and the store is not empty, destination valid is 1. The beat carries min(stored, beat width) bytes in the low lanes, with the unused upper lanes driven to zero.
- R8: Burst codes 0, 1, 2 and 3 mean 1, 4, 8 and 16 beats. If the burst beats times the destination beat bytes exceed the threshold bytes, the error flag sets at the next clock edge. It then stays set until reset, whatever the configuration does afterwards. While the flag is set, source ready, destination valid and burst request are all 0.
- R9: Empty is 1 exactly when no bytes are stored. Full is 1 exactly when 16 bytes are stored.
- R10: Data order is kept across wrap-around of the circular store, including when a push and a pop happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgThreshold | input | 2 | Fill mark code (4/8/12/16 bytes) |
| cfgBurst | input | 2 | Destination burst length code (1/4/8/16 beats) |
| srcSize | input | 2 | Source beat width code |
| dstSize | input | 2 | Destination beat width code |
| srcValid | input | 1 | Source beat offered |
| srcReady | output | 1 | Room for the current source beat |
| srcData | input | 32 | Source beat, valid bytes in the low lanes |
| flush | input | 1 | End of transfer: release partial beats |
| dstReq | output | 1 | Threshold reached, destination burst may start |
| dstValid | output | 1 | A destination beat is available |
| dstReady | input | 1 | Destination takes the beat |
| dstData | output | 32 | Destination beat, oldest byte in lane 0 |
| fifoEmpty | output | 1 | No bytes stored |
| fifoFull | output | 1 | 16 bytes stored |
| fifoErr | output | 1 | Sticky burst/threshold configuration error |

## Verification
Several properties are checked on every cycle. The byte count must equal its previous value plus the bytes pushed minus the bytes popped, and it must never pass 16. Full must block the source, and empty must silence the destination. A raised burst request must always come with a valid beat. The error flag must be sticky and must freeze both sides. Byte values and byte order cannot be seen by these properties, and neither can the exact fill level at which each threshold code fires. Those are shown only by the bench scenarios: packing, unpacking, flushing a partial beat, wrap-around, and the table of legal and illegal burst setups.

// File: rtl/dma_fifo_packer_pkg.sv
package dma_fifo_packer_pkg;

  localparam int LANES = 4;

  typedef struct packed {
    logic       push;
    logic       pop;
    logic [2:0] pushCnt;
    logic [2:0] popCnt;
  } fifoStrobe_t;

  function automatic logic [2:0] beatBytes(input logic [1:0] code);
    case (code)
      2'd0:    beatBytes = 3'd1;
      2'd1:    beatBytes = 3'd2;
      default: beatBytes = 3'd4;
    endcase
  endfunction

  function automatic logic [4:0] burstBeats(input logic [1:0] code);
    case (code)
      2'd0:    burstBeats = 5'd1;
      2'd1:    burstBeats = 5'd4;
      2'd2:    burstBeats = 5'd8;
      default: burstBeats = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/dma_fifo_packer_ctrl.sv
module dma_fifo_packer_ctrl
  import dma_fifo_packer_pkg::*;
#(
  parameter int FIFO_BYTES = 16,
  localparam int PTR_W = $clog2(FIFO_BYTES),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfgThreshold,
  input  logic [1:0]       cfgBurst,
  input  logic [1:0]       srcSize,
  input  logic [1:0]       dstSize,
  input  logic             srcValid,
  input  logic             dstReady,
  input  logic             flush,
  output logic             srcReady,
  output logic             dstValid,
  output logic             dstReq,
  output logic             fifoEmpty,
  output logic             fifoFull,
  output logic             fifoErr,
  output logic [LVL_W-1:0] fillLevel,
  output fifoStrobe_t      strobe
);

  localparam int QUARTER = FIFO_BYTES / 4;

  logic [2:0] srcBytes;
  logic [2:0] dstBytes;
  int         thrBytes;
  logic       cfgBad;
  logic       beatAvail;
  logic       errQ;
  logic [LVL_W-1:0] levelQ;

  always_comb begin
    srcBytes  = beatBytes(srcSize);
    dstBytes  = beatBytes(dstSize);
    thrBytes  = (int'(cfgThreshold) + 1) * QUARTER;
    cfgBad    = (int'(burstBeats(cfgBurst)) * int'(dstBytes)) > thrBytes;
    beatAvail = (int'(levelQ) >= int'(dstBytes)) || (flush && (levelQ != '0));

    srcReady  = !errQ && ((int'(levelQ) + int'(srcBytes)) <= FIFO_BYTES);
    dstValid  = !errQ && beatAvail;
    dstReq    = !errQ && (int'(levelQ) >= thrBytes);

    strobe.push    = srcValid && srcReady;
    strobe.pop     = dstValid && dstReady;
    strobe.pushCnt = srcBytes;
    strobe.popCnt  = (int'(levelQ) < int'(dstBytes)) ? levelQ[2:0] : dstBytes;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      levelQ <= '0;
      errQ   <= 1'b0;
    end else begin
      levelQ <= levelQ
              + (strobe.push ? LVL_W'(strobe.pushCnt) : LVL_W'(0))
              - (strobe.pop  ? LVL_W'(strobe.popCnt)  : LVL_W'(0));
      errQ   <= errQ | cfgBad;
    end
  end

  assign fifoEmpty = (levelQ == '0);
  assign fifoFull  = (int'(levelQ) == FIFO_BYTES);
  assign fifoErr   = errQ;
  assign fillLevel = levelQ;

endmodule

// File: rtl/dma_fifo_packer_data.sv
module dma_fifo_packer_data
  import dma_fifo_packer_pkg::*;
#(
  parameter int FIFO_BYTES = 16,
  localparam int PTR_W = $clog2(FIFO_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  fifoStrobe_t        strobe,
  input  logic [8*LANES-1:0] srcData,
  output logic [8*LANES-1:0] dstData
);

  logic [7:0]       store [FIFO_BYTES];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + PTR_W'(strobe.pushCnt);
      if (strobe.pop)  rdPtr <= rdPtr + PTR_W'(strobe.popCnt);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (strobe.push && (i < int'(strobe.pushCnt)))
        store[wrPtr + PTR_W'(i)] <= srcData[8*i +: 8];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [PTR_W-1:0] rdIdx;
    assign rdIdx = rdPtr + PTR_W'(g);
    assign dstData[8*g +: 8] = (g < int'(strobe.popCnt)) ? store[rdIdx] : 8'h00;
  end

endmodule

// File: rtl/dma_fifo_packer.sv
module dma_fifo_packer
  import dma_fifo_packer_pkg::*;
#(
  parameter int FIFO_BYTES = 16,
  localparam int LVL_W = $clog2(FIFO_BYTES) + 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  cfgThreshold,
  input  logic [1:0]  cfgBurst,
  input  logic [1:0]  srcSize,
  input  logic [1:0]  dstSize,
  input  logic        srcValid,
  output logic        srcReady,
  input  logic [31:0] srcData,
  input  logic        flush,
  output logic        dstReq,
  output logic        dstValid,
  input  logic        dstReady,
  output logic [31:0] dstData,
  output logic        fifoEmpty,
  output logic        fifoFull,
  output logic        fifoErr
);

  fifoStrobe_t      strobe;
  logic [LVL_W-1:0] fillLevel;

  dma_fifo_packer_ctrl #(.FIFO_BYTES(FIFO_BYTES)) uCtrl (
    .clk(clk), .rst(rst),
    .cfgThreshold(cfgThreshold), .cfgBurst(cfgBurst),
    .srcSize(srcSize), .dstSize(dstSize),
    .srcValid(srcValid), .dstReady(dstReady), .flush(flush),
    .srcReady(srcReady), .dstValid(dstValid), .dstReq(dstReq),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .fifoErr(fifoErr),
    .fillLevel(fillLevel), .strobe(strobe)
  );

  dma_fifo_packer_data #(.FIFO_BYTES(FIFO_BYTES)) uData (
    .clk(clk), .rst(rst), .strobe(strobe),
    .srcData(srcData), .dstData(dstData)
  );

endmodule

// File: rtl/dma_fifo_packer_chk.sv
module dma_fifo_packer_chk
  import dma_fifo_packer_pkg::*;
#(
  parameter int FIFO_BYTES = 16,
  localparam int LVL_W = $clog2(FIFO_BYTES) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       srcSize,
  input logic [1:0]       dstSize,
  input logic             srcValid,
  input logic             srcReady,
  input logic             flush,
  input logic             dstReq,
  input logic             dstValid,
  input logic             dstReady,
  input logic             fifoEmpty,
  input logic             fifoFull,
  input logic             fifoErr,
  input logic [LVL_W-1:0] level
);

  int pushed;
  int popped;

  always_comb begin
    pushed = (srcValid && srcReady) ? int'(beatBytes(srcSize)) : 0;
    popped = 0;
    if (dstValid && dstReady)
      popped = (int'(level) < int'(beatBytes(dstSize))) ? int'(level) : int'(beatBytes(dstSize));
  end

  assert_full_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    fifoFull |-> !srcReady);

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= FIFO_BYTES);

  assert_req_has_data_R5: assert property (@(posedge clk) disable iff (rst)
    dstReq |-> dstValid);

  assert_flush_drains_R7: assert property (@(posedge clk) disable iff (rst)
    (flush && !fifoEmpty && !fifoErr) |-> dstValid);

  assert_err_halts_R8: assert property (@(posedge clk) disable iff (rst)
    fifoErr |-> (!srcReady && !dstValid && !dstReq));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    fifoErr |=> fifoErr);

  assert_empty_silent_R9: assert property (@(posedge clk) disable iff (rst)
    fifoEmpty |-> !dstValid);

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(fifoEmpty && fifoFull));

  assert_level_track_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (int'(level) == int'($past(level)) + $past(pushed) - $past(popped)));

endmodule

bind dma_fifo_packer dma_fifo_packer_chk #(.FIFO_BYTES(FIFO_BYTES)) uChk (
  .clk(clk), .rst(rst), .srcSize(srcSize), .dstSize(dstSize),
  .srcValid(srcValid), .srcReady(srcReady), .flush(flush),
  .dstReq(dstReq), .dstValid(dstValid), .dstReady(dstReady),
  .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .fifoErr(fifoErr),
  .level(fillLevel)
);

// File: tb/dma_fifo_packer_test.sv
`timescale 1ns/1ps
module dma_fifo_packer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfgThreshold = 2'd3;
  logic [1:0]  cfgBurst = 2'd0;
  logic [1:0]  srcSize = 2'd2;
  logic [1:0]  dstSize = 2'd2;
  logic        srcValid = 1'b0;
  logic        srcReady;
  logic [31:0] srcData = '0;
  logic        flush = 1'b0;
  logic        dstReq;
  logic        dstValid;
  logic        dstReady = 1'b0;
  logic [31:0] dstData;
  logic        fifoEmpty;
  logic        fifoFull;
  logic        fifoErr;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #2 clk = ~clk;

  dma_fifo_packer uut (
    .clk(clk), .rst(rst), .cfgThreshold(cfgThreshold), .cfgBurst(cfgBurst),
    .srcSize(srcSize), .dstSize(dstSize), .srcValid(srcValid), .srcReady(srcReady),
    .srcData(srcData), .flush(flush), .dstReq(dstReq), .dstValid(dstValid),
    .dstReady(dstReady), .dstData(dstData), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull), .fifoErr(fifoErr)
  );

  // {threshold, burst, dstSize, expected error}
  localparam logic [6:0] VEC [10] = '{
    {2'd3, 2'd1, 2'd2, 1'b0}, {2'd2, 2'd1, 2'd2, 1'b1},
    {2'd0, 2'd0, 2'd2, 1'b0}, {2'd0, 2'd1, 2'd0, 1'b0},
    {2'd0, 2'd1, 2'd1, 1'b1}, {2'd1, 2'd2, 2'd0, 1'b0},
    {2'd1, 2'd3, 2'd0, 1'b1}, {2'd3, 2'd3, 2'd0, 1'b0},
    {2'd3, 2'd2, 2'd1, 1'b0}, {2'd2, 2'd3, 2'd1, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pushBeat(input logic [1:0] sz, input logic [31:0] d);
    srcSize = sz; srcData = d; srcValid = 1'b1;
    @(posedge clk); @(negedge clk);
    srcValid = 1'b0;
  endtask

  task automatic popBeat(output logic [31:0] d);
    d = dstData; dstReady = 1'b1;
    @(posedge clk); @(negedge clk);
    dstReady = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    // R8 table walk
    for (int v = 0; v < 10; v++) begin
      cfgThreshold = VEC[v][6:5]; cfgBurst = VEC[v][4:3]; dstSize = VEC[v][2:1];
      doReset();
      @(negedge clk);
      check(fifoErr == VEC[v][0], "R8 error flag", {31'd0, fifoErr}, {31'd0, VEC[v][0]});
      if (VEC[v][0])
        check(!srcReady && !dstValid && !dstReq, "R8 halt", {29'd0, srcReady, dstValid, dstReq}, 32'd0);
    end
    // R8 sticky: error persists after legal config
    cfgThreshold = 2'd3; cfgBurst = 2'd0; dstSize = 2'd2;
    repeat (2) @(negedge clk);
    check(fifoErr == 1'b1, "R8 sticky", {31'd0, fifoErr}, 32'd1);

    // R1 reset state
    srcSize = 2'd2;
    doReset();
    check(fifoEmpty && !fifoFull && !fifoErr && !dstReq && !dstValid && srcReady, "R1 reset",
          {26'd0, fifoEmpty, fifoFull, fifoErr, dstReq, dstValid, srcReady}, 32'b100001);

    // R3/R6 packing bytes into a word, quarter threshold
    cfgThreshold = 2'd0; dstSize = 2'd2;
    doReset();
    pushBeat(2'd0, 32'h11); pushBeat(2'd0, 32'h22); pushBeat(2'd0, 32'h33);
    check(!dstValid && !dstReq, "R6 partial not valid", {30'd0, dstValid, dstReq}, 32'd0);
    dstReady = 1'b1; @(posedge clk); @(negedge clk); dstReady = 1'b0;
    pushBeat(2'd0, 32'h44);
    check(dstReq, "R5 quarter request", {31'd0, dstReq}, 32'd1);
    popBeat(d);
    check(d == 32'h44332211, "R3 pack order", d, 32'h44332211);
    check(fifoEmpty, "R9 empty after pop", {31'd0, fifoEmpty}, 32'd1);

    // R4 unpack word into bytes
    dstSize = 2'd0;
    pushBeat(2'd2, 32'hAABBCCDD);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] e;
      e = 8'(32'hAABBCCDD >> (8*i));
      popBeat(d);
      check(d == {24'd0, e}, "R4 unpack lane", d, {24'd0, e});
    end

    // R5 threshold levels
    dstSize = 2'd2;
    for (int t = 0; t < 4; t++) begin
      cfgThreshold = 2'(t);
      doReset();
      for (int k = 1; k <= 4; k++) begin
        pushBeat(2'd2, 32'(k));
        check(dstReq == (k >= t + 1), "R5 threshold", {31'd0, dstReq}, {31'd0, k >= t + 1});
      end
      for (int k = 0; k < 4; k++) popBeat(d);
    end

    // R2/R9 back-pressure and full
    cfgThreshold = 2'd3;
    doReset();
    for (int k = 0; k < 7; k++) pushBeat(2'd1, 32'h1000 + 32'(k));
    srcSize = 2'd2; #0.1;
    check(!srcReady, "R2 word blocked at 14", {31'd0, srcReady}, 32'd0);
    srcSize = 2'd1; #0.1;
    check(srcReady, "R2 half fits at 14", {31'd0, srcReady}, 32'd1);
    pushBeat(2'd1, 32'h1007);
    srcSize = 2'd0; #0.1;
    check(fifoFull && !srcReady, "R9 full blocks", {30'd0, fifoFull, srcReady}, 32'b10);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] e;
      e = {16'h1000 + 16'(2*k+1), 16'h1000 + 16'(2*k)};
      popBeat(d);
      check(d == e, "R2 data after full", d, e);
    end
    check(fifoEmpty, "R9 empty after drain", {31'd0, fifoEmpty}, 32'd1);

    // R7 flush of a partial beat
    cfgThreshold = 2'd0;
    pushBeat(2'd0, 32'h5A); pushBeat(2'd0, 32'h6B); pushBeat(2'd0, 32'h7C);
    check(!dstValid, "R6 no flush no beat", {31'd0, dstValid}, 32'd0);
    flush = 1'b1; #0.1;
    check(dstValid, "R7 flush valid", {31'd0, dstValid}, 32'd1);
    popBeat(d);
    check(d == 32'h007C6B5A, "R7 flush data", d, 32'h007C6B5A);
    check(fifoEmpty && !dstValid, "R7 flush drained", {30'd0, fifoEmpty, dstValid}, 32'b10);
    flush = 1'b0;

    // R10 wrap-around with halves into words
    doReset();
    for (int k = 0; k < 12; k++) begin
      pushBeat(2'd1, 32'h2000 + 32'(k));
      if (k % 2 == 1) begin
        logic [31:0] e;
        e = {16'h2000 + 16'(k), 16'h2000 + 16'(k-1)};
        popBeat(d);
        check(d == e, "R10 wrap order", d, e);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule